// File: doc/BRIEF.md
# Page-Mapped Flash Transfer Engine

This block moves bulk data between a byte-wide register port and a serial flash master. A host reaches it through simple register writes and reads with 8-bit register numbers, such as an I2C target front end would supply. The host loads a 24-bit flash address into three byte registers and sets a page length. It then either streams bytes into an on-chip page buffer and starts a page program, or starts a sequential read and drains the returned bytes through the same data-port register. Flash access stays locked until the host has entered programming mode.

A sequencer state machine drives the serial side one byte at a time. Its states are IDLE, CMD (opcode byte), ADR (three address bytes, high byte first), DAT (page bytes) and FIN (one cycle with the frame deselected). The transitions are as follows. IDLE goes to CMD on an accepted start. CMD goes to ADR on a byte acknowledge. ADR goes to DAT after the third acknowledge. DAT goes to FIN after the last page byte is acknowledged. FIN always returns to IDLE. The serial side is a byte exchange: the engine holds `spi_req` with a byte on `spi_txd` until the shifter pulses `spi_ack`, and the received byte on `spi_rxd` is valid in that same cycle.

Top module: `pmx_flash_xfer`

## Requirements
- R1: After reset, register 0x6F reads 0x10, 0x60 reads 0x00, 0x6D reads 0x02, 0x61 reads 0x03 and 0x71 reads 0xFF.
- R2: Registers 0x64, 0x65 and 0x66 hold address bits 23:16, 15:8 and 7:0 and read back what was written. Every frame sends the opcode and then these three bytes in that order.
- R3: Each write to data port 0x70 stores a byte at the next buffer position. Bit 4 of 0x6F (buffer empty) reads 0 once a byte is held. Writes after PAGE_BYTES bytes are held are dropped.
- R4: Writing 0xA0 to 0x6F starts a program frame: the opcode from 0x6D, the address, then the buffered bytes in write order. Bit 5 of 0x6F is 1 while the frame runs. When the frame ends, bit 5 reads 0 and bit 4 reads 1.
- R5: Register 0x71 holds the page length minus one. A frame carries min(value+1, PAGE_BYTES) data bytes.
- R6: Until a write to 0x6F with bit 7 set has been accepted, which sets bit 7 of 0x6F, neither start request produces a frame. The write that sets bit 7 does not itself start a transfer.
- R7: Writing 0x60 with bit 0 set starts a read frame: the opcode from 0x61, the address, then the page length of received bytes, which are stored in order. Bit 0 of 0x60 reads 1 while the frame runs and 0 after it. Bits 7:1 read back as written.
- R8: The first data-port read after a read start returns 0x00 and does not consume a byte. Later reads return the received bytes in order.
- R9: Each accepted start returns both the write and the read position of the data port to the first buffer byte.
- R10: A program request that arrives while a frame is running is ignored. Bit 5 stays 1 and only one frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 8 | Register number |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| spi_cs | output | 1 | Frame select, high for a whole frame |
| spi_req | output | 1 | Byte exchange request |
| spi_txd | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte exchange done pulse |
| spi_rxd | input | 8 | Byte shifted in, valid with spi_ack |

## Verification
The bench builds the engine with PAGE_BYTES set to 16, so a full page takes only a few dozen cycles. With that setting the clamp of a 0xFF length to the buffer size and the dropping of excess data-port writes can both be reached cheaply. A fast flash model acknowledges each byte one cycle after the request. This lets a second program request land well inside a running frame, and it lets the busy bits be caught mid-frame by ordinary register reads.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADR,
        S_DAT,
        S_FIN
    } seq_state_e;

    localparam logic [7:0] RG_CTRL  = 8'h60;
    localparam logic [7:0] RG_RDOP  = 8'h61;
    localparam logic [7:0] RG_ADRH  = 8'h64;
    localparam logic [7:0] RG_ADRM  = 8'h65;
    localparam logic [7:0] RG_ADRL  = 8'h66;
    localparam logic [7:0] RG_AUX   = 8'h6A;
    localparam logic [7:0] RG_PGOP  = 8'h6D;
    localparam logic [7:0] RG_MODE  = 8'h6F;
    localparam logic [7:0] RG_DATA  = 8'h70;
    localparam logic [7:0] RG_LEN   = 8'h71;

    localparam logic [7:0] MODE_GO  = 8'hA0;

endpackage

// File: rtl/pmx_page_buf.sv
`timescale 1ns/1ps
module pmx_page_buf #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra_idx,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_idx,
    output logic [7:0]    rb_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];

endmodule

// File: rtl/pmx_seq.sv
`timescale 1ns/1ps
module pmx_seq
    import pmx_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_pg,
    input  logic [7:0]    op_rd,
    input  logic [7:0]    op_pg,
    input  logic [23:0]   addr,
    input  logic [CW-1:0] nbytes,
    input  logic [7:0]    buf_rdata,
    input  logic          spi_ack,
    input  logic [7:0]    spi_rxd,
    output logic          spi_cs,
    output logic          spi_req,
    output logic [7:0]    spi_txd,
    output logic          buf_we,
    output logic [AW-1:0] buf_idx,
    output logic [7:0]    buf_wdata,
    output logic          busy,
    output logic          is_read
);

    seq_state_e    state;
    logic [CW-1:0] idx;
    logic          rd_q;
    logic [7:0]    op_q;
    logic [23:0]   addr_q;
    logic [CW-1:0] nb_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            idx    <= '0;
            rd_q   <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
            nb_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start_rd || start_pg) begin
                        state  <= S_CMD;
                        rd_q   <= start_rd;
                        op_q   <= start_rd ? op_rd : op_pg;
                        addr_q <= addr;
                        nb_q   <= nbytes;
                        idx    <= '0;
                    end
                end
                S_CMD: begin
                    if (spi_ack) begin
                        state <= S_ADR;
                        idx   <= '0;
                    end
                end
                S_ADR: begin
                    if (spi_ack) begin
                        if (idx == CW'(2)) begin
                            state <= S_DAT;
                            idx   <= '0;
                        end else begin
                            idx <= idx + CW'(1);
                        end
                    end
                end
                S_DAT: begin
                    if (spi_ack) begin
                        if (idx == nb_q - CW'(1)) state <= S_FIN;
                        else                      idx   <= idx + CW'(1);
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_cs  = 1'b0;
        spi_req = 1'b0;
        spi_txd = 8'h00;
        buf_we  = 1'b0;
        unique case (state)
            S_IDLE, S_FIN: ;
            S_CMD: begin
                spi_cs  = 1'b1;
                spi_req = 1'b1;
                spi_txd = op_q;
            end
            S_ADR: begin
                spi_cs  = 1'b1;
                spi_req = 1'b1;
                if (idx == CW'(0))      spi_txd = addr_q[23:16];
                else if (idx == CW'(1)) spi_txd = addr_q[15:8];
                else                    spi_txd = addr_q[7:0];
            end
            S_DAT: begin
                spi_cs  = 1'b1;
                spi_req = 1'b1;
                spi_txd = rd_q ? 8'h00 : buf_rdata;
                buf_we  = rd_q && spi_ack;
            end
            default: ;
        endcase
    end

    assign buf_idx   = idx[AW-1:0];
    assign buf_wdata = spi_rxd;
    assign busy      = (state != S_IDLE);
    assign is_read   = rd_q;

    // R4: a byte on offer is held until the shifter takes it
    p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> $stable(spi_txd));

    // R5: data index never reaches the latched page length
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DAT) |-> (idx < nb_q));

    // R4: the deselect cycle is followed by idle
    p_fin_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIN) |=> !busy);

endmodule

// File: rtl/pmx_flash_xfer.sv
`timescale 1ns/1ps
module pmx_flash_xfer
    import pmx_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_cs,
    output logic       spi_req,
    output logic [7:0] spi_txd,
    input  logic       spi_ack,
    input  logic [7:0] spi_rxd
);

    localparam int AW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(PAGE_BYTES + 1);
    localparam logic [CW-1:0] PB = CW'(PAGE_BYTES);

    logic [7:1]    ctrl_q;
    logic [7:0]    rdop_q, adrh_q, adrm_q, adrl_q, aux_q, pgop_q, len_q;
    logic          isp_q;
    logic [CW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          lead_q;

    logic          busy, seq_rd, pg_busy, rd_busy;
    logic          start_rd, start_pg, host_we;
    logic [CW-1:0] nbytes;
    logic          seq_we;
    logic [AW-1:0] seq_idx;
    logic [7:0]    seq_wdata, seq_rdata, host_rdata;

    assign pg_busy = busy && !seq_rd;
    assign rd_busy = busy && seq_rd;

    assign start_rd = reg_wr && (reg_addr == RG_CTRL) && reg_wdata[0] && isp_q && !busy;
    assign start_pg = reg_wr && (reg_addr == RG_MODE) && (reg_wdata == MODE_GO) && isp_q && !busy;
    assign host_we  = reg_wr && (reg_addr == RG_DATA) && !busy && (wptr < PB);

    assign nbytes = ((int'(len_q) + 1) > PAGE_BYTES) ? PB : CW'(int'(len_q) + 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rdop_q <= 8'h03;
            adrh_q <= '0;
            adrm_q <= '0;
            adrl_q <= '0;
            aux_q  <= '0;
            pgop_q <= 8'h02;
            len_q  <= 8'hFF;
            isp_q  <= 1'b0;
            wptr   <= '0;
            rptr   <= '0;
            lead_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RG_CTRL: ctrl_q <= reg_wdata[7:1];
                    RG_RDOP: rdop_q <= reg_wdata;
                    RG_ADRH: adrh_q <= reg_wdata;
                    RG_ADRM: adrm_q <= reg_wdata;
                    RG_ADRL: adrl_q <= reg_wdata;
                    RG_AUX:  aux_q  <= reg_wdata;
                    RG_PGOP: pgop_q <= reg_wdata;
                    RG_LEN:  len_q  <= reg_wdata;
                    RG_MODE: isp_q  <= isp_q | reg_wdata[7];
                    default: ;
                endcase
            end
            if (host_we) wptr <= wptr + CW'(1);
            if (reg_rd && (reg_addr == RG_DATA)) begin
                if (lead_q) lead_q <= 1'b0;
                else        rptr   <= rptr + AW'(1);
            end
            if (start_rd || start_pg) begin
                wptr   <= '0;
                rptr   <= '0;
                lead_q <= start_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                RG_CTRL: reg_rdata <= {ctrl_q, rd_busy};
                RG_RDOP: reg_rdata <= rdop_q;
                RG_ADRH: reg_rdata <= adrh_q;
                RG_ADRM: reg_rdata <= adrm_q;
                RG_ADRL: reg_rdata <= adrl_q;
                RG_AUX:  reg_rdata <= aux_q;
                RG_PGOP: reg_rdata <= pgop_q;
                RG_LEN:  reg_rdata <= len_q;
                RG_MODE: reg_rdata <= {isp_q, 1'b0, pg_busy, (wptr == '0) && !pg_busy, 4'b0000};
                RG_DATA: reg_rdata <= lead_q ? 8'h00 : host_rdata;
                default: reg_rdata <= 8'h00;
            endcase
        end
    end

    pmx_page_buf #(.DEPTH(PAGE_BYTES), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (seq_we || host_we),
        .widx    (seq_we ? seq_idx : wptr[AW-1:0]),
        .wdata   (seq_we ? seq_wdata : reg_wdata),
        .ra_idx  (seq_idx),
        .ra_data (seq_rdata),
        .rb_idx  (rptr),
        .rb_data (host_rdata)
    );

    pmx_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .start_pg  (start_pg),
        .op_rd     (rdop_q),
        .op_pg     (pgop_q),
        .addr      ({adrh_q, adrm_q, adrl_q}),
        .nbytes    (nbytes),
        .buf_rdata (seq_rdata),
        .spi_ack   (spi_ack),
        .spi_rxd   (spi_rxd),
        .spi_cs    (spi_cs),
        .spi_req   (spi_req),
        .spi_txd   (spi_txd),
        .buf_we    (seq_we),
        .buf_idx   (seq_idx),
        .buf_wdata (seq_wdata),
        .busy      (busy),
        .is_read   (seq_rd)
    );

    // R3: the fill position never passes the buffer size
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= PB);

    // R6: without programming mode an idle engine stays idle
    p_isp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!isp_q && !busy) |=> !busy);

    // R10: a repeated program request mid-frame leaves the frame running
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == RG_MODE) && (reg_wdata == MODE_GO) && pg_busy && spi_cs)
        |=> pg_busy);

    // R4: a byte request only ever appears inside a selected frame
    p_req_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> spi_cs);

endmodule

// File: tb/pmx_flash_xfer_tb.sv
`timescale 1ns/1ps
module pmx_flash_xfer_tb_top;

    localparam int PB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_cs, spi_req, spi_ack;
    logic [7:0] spi_txd, spi_rxd;

    always #10 clk = ~clk;

    pmx_flash_xfer #(.PAGE_BYTES(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_cs(spi_cs), .spi_req(spi_req), .spi_txd(spi_txd),
        .spi_ack(spi_ack), .spi_rxd(spi_rxd)
    );

    // flash model: acknowledge one cycle after a request, log sent bytes
    logic [7:0] fidx;
    logic       prev_cs;
    logic [7:0] log_q [64];
    int         lc = 0;
    int         frames = 0;

    assign spi_rxd = 8'h30 + fidx;

    always @(posedge clk) begin
        if (!rst_n) begin
            spi_ack <= 1'b0;
            fidx    <= '0;
            prev_cs <= 1'b0;
        end else begin
            spi_ack <= spi_req && !spi_ack;
            prev_cs <= spi_cs;
            if (spi_cs && !prev_cs) frames = frames + 1;
            if (spi_req && spi_ack) begin
                if (lc < 64) log_q[lc] = spi_txd;
                lc = lc + 1;
                fidx <= fidx + 8'd1;
            end
            if (!spi_cs) fidx <= '0;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_clear(input logic [7:0] a, input logic [7:0] m, input string tag);
        logic [7:0] v;
        int n = 0;
        do begin
            rd(a, v);
            n++;
        end while (((v & m) != 0) && (n < 500));
        chk({tag, " busy bit clears"}, int'(v & m), 0);
    endtask

    // register write / readback vectors: {reg, write value, expected read}
    localparam logic [23:0] VEC [8] = '{
        {8'h64, 8'h12, 8'h12},
        {8'h65, 8'h34, 8'h34},
        {8'h66, 8'h56, 8'h56},
        {8'h6A, 8'h03, 8'h03},
        {8'h61, 8'h0B, 8'h0B},
        {8'h61, 8'h03, 8'h03},
        {8'h6D, 8'h02, 8'h02},
        {8'h71, 8'h07, 8'h07}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int base, fr;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(8'h6F, v); chk("R1 mode after reset", v, 8'h10);
        rd(8'h60, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(8'h6D, v); chk("R1 program opcode", v, 8'h02);
        rd(8'h61, v); chk("R1 read opcode", v, 8'h03);
        rd(8'h71, v); chk("R1 length", v, 8'hFF);

        // R2 / R5 register table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], v);
            chk($sformatf("R2 readback reg 0x%0h", VEC[i][23:16]), v, VEC[i][7:0]);
        end

        // R6 gating before programming mode
        fr = frames;
        wr(8'h60, 8'h47);
        repeat (20) @(posedge clk);
        chk("R6 no read frame without mode", frames, fr);
        rd(8'h60, v); chk("R6 ctrl not busy", v, 8'h46);
        wr(8'h70, 8'hC0);
        rd(8'h6F, v); chk("R3 empty bit cleared", v, 8'h00);
        wr(8'h6F, 8'hA0);
        repeat (20) @(posedge clk);
        chk("R6 no program frame on mode entry", frames, fr);
        rd(8'h6F, v); chk("R6 mode bit set, idle", v, 8'h80);

        // R4 / R10 program of 8 bytes
        for (int i = 1; i < 8; i++) wr(8'h70, 8'hC0 + 8'(i));
        base = lc; fr = frames;
        wr(8'h6F, 8'hA0);
        rd(8'h6F, v); chk("R4 busy during program", v, 8'hA0);
        wr(8'h6F, 8'hA0);
        rd(8'h6F, v); chk("R10 busy kept after repeat request", v, 8'hA0);
        wait_clear(8'h6F, 8'h20, "R4");
        rd(8'h6F, v); chk("R4 empty after program", v, 8'h90);
        chk("R10 one frame only", frames, fr + 1);
        chk("R4 byte count", lc - base, 12);
        chk("R4 opcode byte", log_q[base], 8'h02);
        chk("R2 address high", log_q[base+1], 8'h12);
        chk("R2 address mid", log_q[base+2], 8'h34);
        chk("R2 address low", log_q[base+3], 8'h56);
        for (int i = 0; i < 8; i++)
            chk($sformatf("R4 data byte %0d", i), log_q[base+4+i], 8'hC0 + i);

        // R3 / R5 overflow and clamp
        wr(8'h71, 8'hFF);
        for (int i = 0; i < 20; i++) wr(8'h70, 8'hD0 + 8'(i));
        base = lc;
        wr(8'h6F, 8'hA0);
        wait_clear(8'h6F, 8'h20, "R5");
        chk("R5 clamped byte count", lc - base, 4 + PB);
        chk("R3 first kept byte", log_q[base+4], 8'hD0);
        chk("R3 last kept byte", log_q[base+4+PB-1], 8'hD0 + PB - 1);

        // R7 / R8 read stream of 6 bytes
        wr(8'h71, 8'h05);
        wr(8'h64, 8'h01); wr(8'h65, 8'h02); wr(8'h66, 8'h00);
        base = lc;
        wr(8'h60, 8'h47);
        rd(8'h60, v); chk("R7 ctrl busy", v, 8'h47);
        wait_clear(8'h60, 8'h01, "R7");
        rd(8'h60, v); chk("R7 ctrl done", v, 8'h46);
        chk("R7 byte count", lc - base, 10);
        chk("R7 read opcode", log_q[base], 8'h03);
        chk("R2 read address high", log_q[base+1], 8'h01);
        chk("R2 read address mid", log_q[base+2], 8'h02);
        chk("R2 read address low", log_q[base+3], 8'h00);
        rd(8'h70, v); chk("R8 leading null", v, 8'h00);
        for (int i = 0; i < 6; i++) begin
            rd(8'h70, v);
            chk($sformatf("R8 stream byte %0d", i), v, 8'h34 + i);
        end

        // R9 pointer restart
        wr(8'h60, 8'h47);
        wait_clear(8'h60, 8'h01, "R9");
        rd(8'h70, v); chk("R9 leading null again", v, 8'h00);
        rd(8'h70, v); chk("R9 stream restarts at first byte", v, 8'h34);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule